// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block watches an already synchronized SMBus clock and data pair for the standard Host Notify transaction. A notifying device sends four bytes to the fixed host address: the host address byte with a write direction, its own 7-bit address, and then a 16-bit data word, low byte first. The receiver acknowledges each byte by pulling the data line low during the ninth clock. The received values are held in shadow registers until the frame ends with a stop. Only then are they copied into the holding registers that host software reads, and only then is a pending flag raised.

While the pending flag is set, the receiver refuses any further notification by not acknowledging the host address byte. The earlier device address and data therefore stay intact until software has read them and pulsed the clear input. An interrupt output gives the pending flag gated by an enable input. A parameter selects whether that output is combinational or registered.

The data line output is an open-drain pull request: 1 means drive the line low. The data line input is the wired-AND of that pull and the external master.

Top module: `hn_notify_rx`

## Requirements
- R1: Only an address byte equal to 0x10 (7-bit address 0001000b followed by a direction bit of 0) is acknowledged. The acknowledge is `sda_pull_o` = 1 for the whole high phase of the ninth clock. Any other first byte, including 0x11 with the read bit, is not acknowledged, and no later byte of that frame is acknowledged or stored.
- R2: While `pending_o` is 1, a matching address byte is not acknowledged, and the held address and data are left unchanged.
- R3: The second byte is acknowledged, and its bits 7:1 become `dev_addr_o` when the frame commits. Bit 0 is dropped.
- R4: The third and fourth bytes are each acknowledged. They become `data_o[7:0]` (third byte) and `data_o[15:8]` (fourth byte).
- R5: The held values are updated and `pending_o` goes to 1 only when a stop follows the acknowledge of the fourth byte. A stop earlier in the frame changes neither `pending_o` nor the held values.
- R6: While `pending_o` is 1 and `sw_clear_i` is 0, `pending_o`, `dev_addr_o` and `data_o` hold their values. A one-cycle `sw_clear_i` pulse makes `pending_o` 0 at the next clock edge and leaves the held values as they were.
- R7: `irq_o` equals `pending_o` AND `irq_en_i` (combinational variant, the default).
- R8: If a frame commits in the same cycle that `sw_clear_i` is 1, `pending_o` is 1 afterwards.
- R9: After reset, `pending_o`, `irq_o` and `sda_pull_o` are 0, and `dev_addr_o` and `data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| sda_pull_o | output | 1 | 1 = drive the data line low (acknowledge) |
| sw_clear_i | input | 1 | One-cycle pulse that clears the pending flag |
| irq_en_i | input | 1 | Interrupt enable |
| pending_o | output | 1 | Notification captured and not yet serviced |
| irq_o | output | 1 | Interrupt request |
| dev_addr_o | output | 7 | Held address of the notifying device |
| data_o | output | 16 | Held data word, high byte in bits 15:8 |

## Verification
The main frame is driven with several address and data patterns: all-ones and all-zeros bytes in each data position, and a device byte whose bit 0 is set. This shows that the bytes are placed in the right order and that bit 0 is dropped. First bytes that differ from the host address in a low bit, in the direction bit and in the top bit each show that matching is exact and that a refused frame stores nothing. Further directed frames cover refusal while a notification is pending, stops after the second and third bytes, a clear that coincides with a commit, and the interrupt with the enable both off and on.

// File: rtl/hn_pkg.sv
package hn_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_ACK   = 2'd2,
      ST_DONE  = 2'd3
   } hn_state_e;
endpackage

// File: rtl/hn_bus_events.sv
module hn_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   // data edges while the clock stays high mark frame boundaries
   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/hn_frame_fsm.sv
module hn_frame_fsm
   import hn_pkg::*;
#(
   parameter int unsigned            ADDR_W     = 7,
   parameter logic [ADDR_W-1:0]      HOST_ADDR  = 7'h08,
   parameter int unsigned            DATA_BYTES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sda_i,
   input  logic                      start_i,
   input  logic                      stop_i,
   input  logic                      scl_rise_i,
   input  logic                      scl_fall_i,
   input  logic                      pending_i,
   output logic                      sda_pull_o,
   output logic                      frame_done_o,
   output logic [ADDR_W-1:0]         shd_dev_o,
   output logic [8*DATA_BYTES-1:0]   shd_data_o
);
   localparam int unsigned NBYTES = DATA_BYTES + 2;
   localparam int unsigned IDX_W  = $clog2(NBYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

   hn_state_e         state;
   logic [7:0]        shreg;
   logic [3:0]        bitcnt;
   logic [IDX_W-1:0]  idx;
   logic              byte_end;
   logic              addr_ok;

   assign byte_end     = scl_fall_i && (state == ST_SHIFT) && (bitcnt == 4'd8);
   assign addr_ok      = (shreg == {HOST_ADDR, 1'b0}) && !pending_i;
   assign frame_done_o = stop_i && (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         shreg      <= '0;
         bitcnt     <= '0;
         idx        <= '0;
         sda_pull_o <= 1'b0;
      end else if (start_i) begin
         state      <= ST_SHIFT;
         bitcnt     <= '0;
         idx        <= '0;
         sda_pull_o <= 1'b0;
      end else if (stop_i) begin
         state      <= ST_IDLE;
         sda_pull_o <= 1'b0;
      end else begin
         unique case (state)
            ST_SHIFT: begin
               if (scl_rise_i && bitcnt != 4'd8) begin
                  shreg  <= {shreg[6:0], sda_i};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_end) begin
                  if (idx == '0 && !addr_ok) begin
                     state <= ST_IDLE;
                  end else begin
                     state      <= ST_ACK;
                     sda_pull_o <= 1'b1;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall_i) begin
                  sda_pull_o <= 1'b0;
                  bitcnt     <= '0;
                  if (idx == LAST_IDX) begin
                     state <= ST_DONE;
                  end else begin
                     state <= ST_SHIFT;
                     idx   <= idx + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // shadow capture, one register per byte position
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       shd_dev_o <= '0;
      else if (byte_end && idx == IDX_W'(1)) shd_dev_o <= shreg[7:1];
   end

   logic [7:0] shd_b [DATA_BYTES];
   for (genvar k = 0; k < DATA_BYTES; k++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               shd_b[k] <= '0;
         else if (byte_end && idx == IDX_W'(k + 2)) shd_b[k] <= shreg;
      end
      assign shd_data_o[8*k +: 8] = shd_b[k];
   end

   AST_PEND_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && idx == '0 && pending_i) |=> !sda_pull_o); // R2
   AST_ADDR_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && idx == '0 && shreg != {HOST_ADDR, 1'b0}) |=> !sda_pull_o); // R1
endmodule

// File: rtl/hn_hold_regs.sv
module hn_hold_regs #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic              sw_clear_i,
   input  logic              irq_en_i,
   input  logic [ADDR_W-1:0] shd_dev_i,
   input  logic [DATA_W-1:0] shd_data_i,
   output logic              pending_o,
   output logic [ADDR_W-1:0] dev_addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_o  <= 1'b0;
         dev_addr_o <= '0;
         data_o     <= '0;
      end else if (commit_i) begin
         pending_o  <= 1'b1;
         dev_addr_o <= shd_dev_i;
         data_o     <= shd_data_i;
      end else if (sw_clear_i) begin
         pending_o  <= 1'b0;
      end
   end

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= pending_o & irq_en_i;
      end
   end else begin : g_irq_comb
      assign irq_o = pending_o & irq_en_i;
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         (!irq_en_i || !pending_o) |-> !irq_o); // R7
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && !sw_clear_i) |=> (pending_o && $stable(dev_addr_o) && $stable(data_o))); // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && sw_clear_i) |=> pending_o); // R8
endmodule

// File: rtl/hn_notify_rx.sv
module hn_notify_rx #(
   parameter logic [6:0]  HOST_ADDR  = 7'h08,
   parameter int unsigned DATA_BYTES = 2,
   parameter bit          IRQ_REG    = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_pull_o,
   input  logic                    sw_clear_i,
   input  logic                    irq_en_i,
   output logic                    pending_o,
   output logic                    irq_o,
   output logic [6:0]              dev_addr_o,
   output logic [8*DATA_BYTES-1:0] data_o
);
   localparam int unsigned ADDR_W = 7;
   localparam int unsigned DATA_W = 8 * DATA_BYTES;

   if (DATA_BYTES < 1 || DATA_BYTES > 4) begin : g_bad_cfg
      $error("hn_notify_rx: DATA_BYTES must be 1 to 4");
   end

   logic start_w, stop_w, rise_w, fall_w, done_w;
   logic [ADDR_W-1:0] shd_dev;
   logic [DATA_W-1:0] shd_data;

   hn_bus_events u_evt (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .start_o(start_w), .stop_o(stop_w),
      .scl_rise_o(rise_w), .scl_fall_o(fall_w)
   );

   hn_frame_fsm #(
      .ADDR_W(ADDR_W), .HOST_ADDR(HOST_ADDR), .DATA_BYTES(DATA_BYTES)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
      .start_i(start_w), .stop_i(stop_w),
      .scl_rise_i(rise_w), .scl_fall_i(fall_w),
      .pending_i(pending_o), .sda_pull_o(sda_pull_o),
      .frame_done_o(done_w), .shd_dev_o(shd_dev), .shd_data_o(shd_data)
   );

   hn_hold_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_REG(IRQ_REG)
   ) u_hold (
      .clk(clk), .rst_n(rst_n), .commit_i(done_w),
      .sw_clear_i(sw_clear_i), .irq_en_i(irq_en_i),
      .shd_dev_i(shd_dev), .shd_data_i(shd_data),
      .pending_o(pending_o), .dev_addr_o(dev_addr_o),
      .data_o(data_o), .irq_o(irq_o)
   );

   AST_NO_EARLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending_o && !done_w) |=> !pending_o); // R5
endmodule

// File: tb/sim_hn_notify_rx.sv
module sim_hn_notify_rx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sw_clear = 1'b0, irq_en = 1'b0;
   logic sda_pull, pending, irq;
   logic [6:0]  dev_addr;
   logic [15:0] data;
   logic sda_line;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   localparam int Q = 4;

   always #10 clk = ~clk;   // 50 MHz

   assign sda_line = sda_m & ~sda_pull;

   hn_notify_rx u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .sw_clear_i(sw_clear), .irq_en_i(irq_en),
      .pending_o(pending), .irq_o(irq), .dev_addr_o(dev_addr), .data_o(data)
   );

   // {addr byte, device byte, low byte, high byte, address acked}
   localparam int NV = 6;
   localparam logic [32:0] VEC [NV] = '{
      {8'h10, 8'hA4, 8'h34, 8'h12, 1'b1},
      {8'h10, 8'h5F, 8'hFF, 8'h00, 1'b1},
      {8'h10, 8'hFE, 8'h00, 8'hFF, 1'b1},
      {8'h12, 8'h22, 8'h33, 8'h44, 1'b0},
      {8'h11, 8'h22, 8'h33, 8'h44, 1'b0},
      {8'h90, 8'h66, 8'h77, 8'h88, 1'b0}
   };

   logic [6:0]  exp_dev = '0;
   logic [15:0] exp_data = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic w();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; w();
      sda_m = 1'b0; w();
      scl_m = 1'b0; w();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w();
      scl_m = 1'b1; w();
      sda_m = 1'b1; w();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; w();
         scl_m = 1'b1; w();
         scl_m = 1'b0; w();
      end
      sda_m = 1'b1; w();
      scl_m = 1'b1;
      @(negedge clk);
      ack = !sda_line;
      w();
      ack = ack && !sda_line;   // held low for the whole high phase
      scl_m = 1'b0; w();
   endtask

   // sends up to nb bytes; stops early on a refused address byte
   task automatic frame(input logic [7:0] a, d, lo, hi, input int nb, output bit [3:0] acks);
      logic [7:0] bs [4];
      bit k;
      bs[0] = a; bs[1] = d; bs[2] = lo; bs[3] = hi;
      acks = '0;
      bus_start();
      for (int i = 0; i < nb; i++) begin
         send_byte(bs[i], k);
         acks[i] = k;
         if (i == 0 && !k) break;
      end
   endtask

   task automatic clear_pulse();
      sw_clear = 1'b1; @(negedge clk);
      sw_clear = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit [3:0] acks;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(pending == 1'b0 && irq == 1'b0 && sda_pull == 1'b0, "R9 flags", {pending, irq, sda_pull}, 0);
      chk(dev_addr == '0 && data == '0, "R9 holds", {dev_addr, data}, 0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic [7:0] a, d, lo, hi;
         bit ea;
         {a, d, lo, hi, ea} = VEC[v];
         frame(a, d, lo, hi, 4, acks);
         bus_stop();
         @(negedge clk);
         chk(acks[0] == ea, "R1 address ack", acks[0], ea);
         if (ea) begin
            exp_dev = d[7:1];
            exp_data = {hi, lo};
            chk(acks[1], "R3 device byte ack", acks[1], 1);
            chk(acks[3:2] == 2'b11, "R4 data byte acks", acks[3:2], 2'b11);
            chk(pending == 1'b1, "R5 pending after stop", pending, 1);
         end else begin
            chk(pending == 1'b0, "R1 refused frame no pending", pending, 0);
         end
         chk(dev_addr == exp_dev, "R3 device address", dev_addr, exp_dev);
         chk(data == exp_data, "R4 data word", data, exp_data);
         clear_pulse();
         chk(pending == 1'b0, "R6 clear", pending, 0);
         chk(dev_addr == exp_dev && data == exp_data, "R6 clear keeps holds", {dev_addr, data}, {exp_dev, exp_data});
      end

      // R2: pending refuses new notify and keeps data
      frame(8'h10, 8'h30, 8'hC3, 8'h3C, 4, acks); bus_stop(); @(negedge clk);
      exp_dev = 7'h18; exp_data = 16'h3CC3;
      chk(pending == 1'b1, "R5 commit", pending, 1);
      frame(8'h10, 8'h02, 8'h55, 8'hAA, 4, acks); bus_stop(); @(negedge clk);
      chk(acks[0] == 1'b0, "R2 address nack while pending", acks[0], 0);
      chk(dev_addr == exp_dev && data == exp_data, "R2 holds kept", {dev_addr, data}, {exp_dev, exp_data});
      chk(pending == 1'b1, "R6 pending held", pending, 1);

      // R7 interrupt gating
      irq_en = 1'b0; @(negedge clk);
      chk(irq == 1'b0, "R7 irq disabled", irq, 0);
      irq_en = 1'b1; @(negedge clk);
      chk(irq == 1'b1, "R7 irq enabled", irq, 1);
      clear_pulse();
      chk(irq == 1'b0 && pending == 1'b0, "R7 irq after clear", {irq, pending}, 0);
      irq_en = 1'b0;

      // R5 aborted frames: stop after byte 2 and after byte 3
      frame(8'h10, 8'h44, 8'h99, 8'h00, 2, acks); bus_stop(); @(negedge clk);
      chk(pending == 1'b0 && dev_addr == exp_dev && data == exp_data, "R5 abort after byte 2",
          {pending, dev_addr, data}, {1'b0, exp_dev, exp_data});
      frame(8'h10, 8'h44, 8'h99, 8'h00, 3, acks); bus_stop(); @(negedge clk);
      chk(pending == 1'b0 && dev_addr == exp_dev && data == exp_data, "R5 abort after byte 3",
          {pending, dev_addr, data}, {1'b0, exp_dev, exp_data});

      // R8 clear coinciding with commit
      frame(8'h10, 8'h7E, 8'h01, 8'h80, 4, acks);
      exp_dev = 7'h3F; exp_data = 16'h8001;
      sda_m = 1'b0; w();
      scl_m = 1'b1; w();
      sda_m = 1'b1; sw_clear = 1'b1;
      @(negedge clk);
      sw_clear = 1'b0;
      chk(pending == 1'b1, "R8 set wins over clear", pending, 1);
      chk(dev_addr == exp_dev && data == exp_data, "R8 values committed", {dev_addr, data}, {exp_dev, exp_data});
      w();
      clear_pulse();
      chk(pending == 1'b0, "R6 final clear", pending, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule